// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a supervision timer for a processor subsystem. A free-running prescaler divides the bus clock into a slow base tick. A second stage counts those ticks up to a limit set by a 2-bit rate select. If software does not service the timer before that stage runs out, the block emits a one-clock reset-request pulse, restarts its interval and keeps counting.

Servicing takes two writes to a single byte-wide service port. The arm value 0x55 comes first. The clear value 0xAA then restarts the interval. Any stray write, or a lone clear, leaves the timer running. The prescaler is never cleared by servicing, so the time until a timeout is never shorter than the nominal interval and may be up to one base period longer. With a 2 MHz bus clock and the default divisor, the nominal intervals are about 16.4 ms, 65.5 ms, 262 ms and 1.05 s.

Top module: `keyed_watchdog`

## Requirements
- R1: The base tick occurs once every BASE_DIV clocks (default 32768) from a prescaler that is cleared only by `rst`. Service writes and the enable input do not alter its phase.
- R2: The rate select sets the interval N in base periods as 00→1, 01→4, 10→16 and 11→64. A request fires between N·BASE_DIV+1 and (N+1)·BASE_DIV clocks after the clock edge that samples a successful clear.
- R3: `rst_req` is high for exactly one clock. The interval count then restarts from zero, so the next request without service follows exactly (N+1)·BASE_DIV clocks later.
- R4: A write of 0x55 arms the block. A write of 0xAA while armed restarts the interval and disarms the block, so a second 0xAA then has no effect.
- R5: A write of 0xAA while not armed has no effect on the interval or on the request timing.
- R6: A write of any value other than 0x55 or 0xAA leaves the arm state as it was. A repeated 0x55 keeps the block armed.
- R7: While `wd_en` is low, the interval count is held at zero, no request is produced and the arm state is cleared.
- R8: The rate select takes effect only at an interval rollover, at a clear, or while disabled. A change in mid-interval cannot shorten the interval that is running.
- R9: When a clear and the terminal base tick fall on the same clock, the clear wins and no request is produced.
- R10: After `rst`, `rst_req` is low, the block is unarmed, the interval count and the prescaler are zero, and the rate select is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_en | input | 1 | Watchdog enable |
| rate_sel | input | 2 | Interval length select |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| rst_req | output | 1 | Single-clock reset request on timeout |

## Verification
A successful clear and the terminal base tick can land on the same clock edge. In that case the restart and the timeout both claim the interval counter. The bench first learns the tick phase from an earlier request. It arms the block, then places the 0xAA write exactly on the edge where the next request is due. The outcome is judged correct if no pulse appears on that edge and the next pulse arrives a full (N+1) base periods later.

// File: rtl/kw_pkg.sv
package kw_pkg;

    localparam logic [7:0] KEY_ARM   = 8'h55;
    localparam logic [7:0] KEY_CLEAR = 8'hAA;

    localparam int RATE_SEL_W = 2;
    localparam int RATE_CNT_W = 2 * ((1 << RATE_SEL_W) - 1) + 1;

    typedef logic [RATE_SEL_W-1:0] rate_sel_t;
    typedef logic [RATE_CNT_W-1:0] rate_cnt_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } svc_write_t;

    typedef struct packed {
        rate_cnt_t count;
        rate_cnt_t term;
    } rate_state_t;

    // Interval length in base periods: 4 to the power of the select.
    function automatic rate_cnt_t rate_terminal(input rate_sel_t sel);
        return rate_cnt_t'(1) << (2 * sel);
    endfunction

endpackage

// File: rtl/kw_prescaler.sv
module kw_prescaler #(
    parameter int BASE_DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(BASE_DIV - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + W'(1);
        end
    end

endmodule

// File: rtl/kw_key_seq.sv
module kw_key_seq
    import kw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  svc_write_t svc,
    output logic       armed,
    output logic       clear
);
    key_state_e state_q, state_d;

    assign armed = (state_q == KEY_ARMED);

    always_comb begin
        state_d = state_q;
        clear   = 1'b0;
        if (!en) begin
            state_d = KEY_IDLE;
        end else if (svc.wr) begin
            if (svc.data == KEY_ARM) begin
                state_d = KEY_ARMED;
            end else if (svc.data == KEY_CLEAR && state_q == KEY_ARMED) begin
                clear   = 1'b1;
                state_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/kw_rate_stage.sv
module kw_rate_stage
    import kw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      clear,
    input  rate_sel_t rate_sel,
    output logic      timeout,
    output rate_cnt_t count,
    output rate_cnt_t term
);
    rate_state_t st_q, st_d;
    logic        fire;

    assign count = st_q.count;
    assign term  = st_q.term;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!en) begin
            st_d.count = '0;
            st_d.term  = rate_terminal(rate_sel);
        end else if (clear) begin
            st_d.count = '0;
            st_d.term  = rate_terminal(rate_sel);
        end else if (tick) begin
            if (st_q.count == st_q.term) begin
                fire       = 1'b1;
                st_d.count = '0;
                st_d.term  = rate_terminal(rate_sel);
            end else begin
                st_d.count = st_q.count + rate_cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.count <= '0;
            st_q.term  <= rate_terminal(rate_sel);
            timeout    <= 1'b0;
        end else begin
            st_q    <= st_d;
            timeout <= fire;
        end
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kw_pkg::*;
#(
    parameter int BASE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_en,
    input  logic [1:0] rate_sel,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       rst_req
);
    logic       base_tick;
    logic       key_armed;
    logic       key_clear;
    svc_write_t svc;
    rate_cnt_t  rate_count;
    rate_cnt_t  rate_term;

    assign svc.wr   = svc_wr;
    assign svc.data = svc_data;

    kw_prescaler #(
        .BASE_DIV(BASE_DIV)
    ) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(base_tick)
    );

    kw_key_seq u_key (
        .clk  (clk),
        .rst  (rst),
        .en   (wd_en),
        .svc  (svc),
        .armed(key_armed),
        .clear(key_clear)
    );

    kw_rate_stage u_rate (
        .clk     (clk),
        .rst     (rst),
        .en      (wd_en),
        .tick    (base_tick),
        .clear   (key_clear),
        .rate_sel(rate_sel_t'(rate_sel)),
        .timeout (rst_req),
        .count   (rate_count),
        .term    (rate_term)
    );

endmodule

// File: rtl/kw_checker.sv
module kw_checker
    import kw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wd_en,
    input logic       svc_wr,
    input logic [7:0] svc_data,
    input logic       rst_req,
    input logic       armed,
    input rate_cnt_t  count,
    input rate_cnt_t  term
);
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!rst_req && !armed && count == '0));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> (!rst_req && !armed && count == '0));

    p_arm_r4: assert property (@(posedge clk) disable iff (rst)
        (wd_en && svc_wr && svc_data == 8'h55) |=> armed);

    // R9: a clear beats a coincident terminal tick
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (wd_en && armed && svc_wr && svc_data == 8'hAA)
            |=> (!armed && !rst_req && count == '0));

    p_unarmed_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wd_en && !armed && svc_wr && svc_data == 8'hAA) |=> !armed);

    p_other_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wd_en && svc_wr && svc_data != 8'h55 && svc_data != 8'hAA)
            |=> (armed == $past(armed)));

    p_rate_latch_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(term) |-> (count == '0));

    always @(posedge clk) begin
        if (!rst) begin
            p_count_bound_r2: assert (count <= term);
        end
    end

endmodule

bind keyed_watchdog kw_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wd_en   (wd_en),
    .svc_wr  (svc_wr),
    .svc_data(svc_data),
    .rst_req (rst_req),
    .armed   (key_armed),
    .count   (rate_count),
    .term    (rate_term)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;
    localparam int MAX_CYC = 100000;

    typedef struct packed {
        logic [1:0]  sel;
        int unsigned n;
        int unsigned phase;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1,  0}, '{2'd0, 1,  5},
        '{2'd1, 4,  2}, '{2'd1, 4,  7},
        '{2'd2, 16, 1}, '{2'd2, 16, 4},
        '{2'd3, 64, 3}, '{2'd3, 64, 6}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_en = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rst_req;

    int cyc = 0;
    int n_checks = 0;
    int n_err = 0;

    keyed_watchdog #(.BASE_DIV(D)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wd_en   (wd_en),
        .rate_sel(rate_sel),
        .svc_wr  (svc_wr),
        .svc_data(svc_data),
        .rst_req (rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc > MAX_CYC) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, MAX_CYC);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write sampled by the rising edge numbered t.
    task automatic drive_at(input int t, input logic [7:0] d);
        while (cyc < t - 1) @(negedge clk);
        svc_wr   = 1'b1;
        svc_data = d;
        @(negedge clk);
        svc_wr   = 1'b0;
        svc_data = 8'h00;
    endtask

    // Edge number of the next request pulse.
    task automatic wait_pulse(output int p);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!rst_req && guard < 2000);
        if (!rst_req) begin
            check(1'b0, "pulse-missing", guard, 0);
        end
        p = cyc;
    endtask

    initial begin
        int e, p, p2, c, lo, hi;
        bit quiet;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rst_req == 1'b0, "R10 reset output", int'(rst_req), 0);

        quiet = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (rst_req) quiet = 1'b0;
        end
        check(quiet, "R7 disabled after reset", int'(quiet), 1);

        // Table walk: window from clear (R2) and free-run period (R3).
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wd_en    = 1'b0;
            rate_sel = VECS[i].sel;
            repeat (2) @(negedge clk);
            wd_en = 1'b1;
            drive_at(cyc + 2, 8'h55);
            c = cyc + 3 + int'(VECS[i].phase);
            drive_at(c, 8'hAA);
            wait_pulse(p);
            lo = c + int'(VECS[i].n) * D + 1;
            hi = c + (int'(VECS[i].n) + 1) * D;
            check(p >= lo && p <= hi, "R2 window low", p - c, lo - c);
            check(p <= hi, "R2 window high", p - c, hi - c);
            @(negedge clk);
            check(rst_req == 1'b0, "R3 one-clock pulse", int'(rst_req), 0);
            wait_pulse(p2);
            check(p2 - p == (int'(VECS[i].n) + 1) * D, "R3 period",
                  p2 - p, (int'(VECS[i].n) + 1) * D);
        end

        // R8: mid-interval change from 11 to 00 does not cut the interval.
        wait_pulse(e);
        @(negedge clk);
        rate_sel = 2'd0;
        wait_pulse(p);
        check(p == e + 65 * D, "R8 no short interval", p - e, 65 * D);
        wait_pulse(p2);
        check(p2 == p + 2 * D, "R8 new rate at rollover", p2 - p, 2 * D);

        // R1/R7: disable holds, clears arm, prescaler keeps its phase.
        e = p2;
        drive_at(e + 2, 8'h55);
        wd_en = 1'b0;
        quiet = 1'b1;
        while (cyc < e + 204) begin
            @(negedge clk);
            if (rst_req) quiet = 1'b0;
        end
        check(quiet, "R7 no request while disabled", int'(quiet), 1);
        wd_en = 1'b1;
        drive_at(e + 210, 8'hAA);
        wait_pulse(p);
        check(p == e + 216, "R1 R7 phase kept and arm dropped", p - e, 216);

        // R9: clear on the terminal tick edge.
        e = p;
        drive_at(e + 3, 8'h55);
        drive_at(e + 2 * D, 8'hAA);
        wait_pulse(p);
        check(p == e + 4 * D, "R9 clear wins", p - e, 4 * D);

        // R5: lone clear, rate 01.
        rate_sel = 2'd1;
        wait_pulse(e);
        drive_at(e + 10, 8'hAA);
        wait_pulse(p);
        check(p == e + 5 * D, "R5 unarmed clear ignored", p - e, 5 * D);

        // R4: clear restarts, second clear without arm ignored.
        e = p;
        drive_at(e + 2, 8'h55);
        drive_at(e + 10, 8'hAA);
        drive_at(e + 20, 8'hAA);
        wait_pulse(p);
        check(p == e + 6 * D, "R4 clear then disarm", p - e, 6 * D);

        // R6: stray values keep arm, repeated arm allowed.
        e = p;
        drive_at(e + 2, 8'h55);
        drive_at(e + 4, 8'h3C);
        drive_at(e + 6, 8'h55);
        drive_at(e + 8, 8'h00);
        drive_at(e + 10, 8'hAA);
        wait_pulse(p);
        check(p == e + 6 * D, "R6 arm held through stray writes", p - e, 6 * D);

        // R10: mid-run reset restarts prescaler and samples rate.
        rate_sel = 2'd0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_req == 1'b0, "R10 request low in reset", int'(rst_req), 0);
        c = cyc;
        rst = 1'b0;
        wait_pulse(p);
        check(p == c + 2 * D, "R10 restart after reset", p - c, 2 * D);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule